// File: doc/BRIEF.md
# SPI Master with Buffered Data Port

This block is an 8-bit SPI master placed behind a small register bus. One data location serves both directions: writing it fills a one-byte transmit holding buffer, and reading it returns a one-byte receive holding buffer. A status location reports whether the transmit buffer can take a byte and whether the receive buffer holds one. A control location holds one bit that enables transmit DMA. The serial side runs SPI mode 0, most significant bit first. SCLK comes from a parameterised divider. Chip select stays low while queued bytes follow each other.

Writes to the data location are guarded. With DMA off, software must first read the status location while the transmit-empty flag is set. A write made without that read is dropped. With DMA on, a write is accepted whenever the transmit buffer is empty, and a DMA request output shows when this is so. If a frame ends while an unread byte still sits in the receive buffer, the new byte is dropped, the old byte is kept, and nothing reports the loss.

Three state machines do the work. The serial engine has states SH_IDLE, SH_LOW, SH_HIGH and SH_TAIL:
- SH_IDLE goes to SH_LOW when a byte is waiting.
- SH_LOW goes to SH_HIGH on a divider tick.
- On a divider tick, SH_HIGH goes to SH_LOW for the next bit. After the last bit it goes straight to SH_LOW if another byte is waiting, otherwise to SH_TAIL.
- SH_TAIL goes to SH_IDLE on a tick.

The transmit buffer has states TXB_EMPTY, TXB_ARMED and TXB_FULL:
- TXB_EMPTY goes to TXB_ARMED on a status read.
- TXB_EMPTY goes to TXB_FULL on a data write with DMA enabled.
- TXB_ARMED goes to TXB_FULL on any data write.
- TXB_FULL goes to TXB_EMPTY when the engine takes the byte.

The receive buffer has states RXB_EMPTY, RXB_FULL and RXB_ARMED:
- RXB_EMPTY goes to RXB_FULL when a frame ends.
- RXB_FULL goes to RXB_ARMED on a status read.
- RXB_ARMED goes to RXB_EMPTY on a data read.
- RXB_ARMED goes to RXB_FULL when a data read and a frame end fall in the same cycle.

Top module: `spi_buffered_master`

## Requirements
- R1: After reset the data location reads 0x00 and the status location reads 0x02. Status bit 1 is transmit-empty, bit 0 is receive-full, and the other bits are zero. cs_n is high, sclk is low and dma_req is low.
- R2: With DMA off, a data write (bus address 2) that is not preceded by a status read (bus address 0) seen with transmit-empty set is ignored. No frame starts.
- R3: A status read seen with transmit-empty set arms one data write. The accepted write clears the arm, so a further write without a new status read is ignored. The accepted byte is shifted out MSB first, with MOSI stable while SCLK is high.
- R4: dma_req is high exactly while DMA is enabled (control bit 0 at bus address 1) and transmit-empty is set. In that state a data write is accepted without a status read.
- R5: A data write while the transmit buffer is full is ignored, and the buffered byte is the one sent.
- R6: A byte waiting in the transmit buffer when a frame ends starts at once. cs_n stays low, and the gap between the last SCLK rise of one frame and the first rise of the next is one SCLK period.
- R7: MISO is sampled on each SCLK rise, MSB first. At frame end the byte goes into an empty receive buffer and receive-full is set.
- R8: Receive-full is cleared only by a status read that sees it set, followed by a data read. A data read without that status read leaves it set.
- R9: A frame that ends while the receive buffer is full is discarded, the old byte is kept, and status shows no sign of it.
- R10: When the clearing data read and a frame end fall in the same cycle, the read returns the old byte, the new byte is stored, and receive-full stays set.
- R11: Each SCLK half period lasts HALF_DIV clock cycles, and cs_n is high whenever no frame is in flight.
- R12: Transmit-empty is set again in the cycle after the engine takes the buffered byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | 0 status, 1 control, 2 data |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, combinational from the address |
| dma_req | output | 1 | Transmit DMA request |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Chip select, active low |

## Verification
A data read that clears receive-full can land in the same clock edge at which the engine finishes a frame. The bench counts SCLK rises, waits HALF_DIV-1 edges after the eighth rise, and issues the data read so that it coincides with the frame-end edge. It then expects the old byte on the read, receive-full still set afterwards, and the newly shifted byte on the next armed read. A second overlap, a frame end arriving while a byte is already queued, is judged by cs_n staying low and by the spacing of the SCLK rises.

// File: rtl/spibm_pkg.sv
package spibm_pkg;
    localparam logic [1:0] REG_STAT = 2'd0;
    localparam logic [1:0] REG_CTRL = 2'd1;
    localparam logic [1:0] REG_DATA = 2'd2;

    localparam int STAT_RXF_BIT = 0;
    localparam int STAT_TXE_BIT = 1;
    localparam int CTRL_DMA_BIT = 0;

    typedef enum logic [1:0] {SH_IDLE, SH_LOW, SH_HIGH, SH_TAIL} sh_state_t;
    typedef enum logic [1:0] {TXB_EMPTY, TXB_ARMED, TXB_FULL} txb_state_t;
    typedef enum logic [1:0] {RXB_EMPTY, RXB_FULL, RXB_ARMED} rxb_state_t;
endpackage

// File: rtl/spibm_clkdiv.sv
module spibm_clkdiv #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_q;

    assign tick = run && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt_q <= '0;
        else if (!run || tick) cnt_q <= '0;
        else                 cnt_q <= cnt_q + 1'b1;
    end

    generate
        if (HALF_DIV > 1) begin : g_gap_chk
            // R11: ticks are separated by at least one idle cycle
            p_tick_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/spibm_shifter.sv
module spibm_shifter
    import spibm_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          tx_full,
    input  logic [DW-1:0] tx_data,
    input  logic          miso,
    output logic          run,
    output logic          take,
    output logic          done,
    output logic [DW-1:0] rx_byte,
    output logic          sclk,
    output logic          mosi,
    output logic          cs_n
);
    localparam int BW = (DW > 1) ? $clog2(DW) : 1;
    localparam logic [BW-1:0] LAST_BIT = BW'(DW - 1);

    sh_state_t     state_q, state_d;
    logic [DW-1:0] tsh_q, rsh_q;
    logic [BW-1:0] bit_q;
    logic          last;

    assign last = (bit_q == LAST_BIT);

    always_comb begin
        state_d = state_q;
        take    = 1'b0;
        done    = 1'b0;
        unique case (state_q)
            SH_IDLE: begin
                if (tx_full) begin
                    take    = 1'b1;
                    state_d = SH_LOW;
                end
            end
            SH_LOW: begin
                if (tick) state_d = SH_HIGH;
            end
            SH_HIGH: begin
                if (tick) begin
                    if (last) begin
                        done = 1'b1;
                        if (tx_full) begin
                            take    = 1'b1;
                            state_d = SH_LOW;
                        end else begin
                            state_d = SH_TAIL;
                        end
                    end else begin
                        state_d = SH_LOW;
                    end
                end
            end
            SH_TAIL: begin
                if (tick) state_d = SH_IDLE;
            end
            default: state_d = SH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SH_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tsh_q <= '0;
            rsh_q <= '0;
            bit_q <= '0;
        end else begin
            if (take) begin
                tsh_q <= tx_data;
                bit_q <= '0;
            end else if (state_q == SH_HIGH && tick && !last) begin
                tsh_q <= {tsh_q[DW-2:0], 1'b0};
                bit_q <= bit_q + 1'b1;
            end
            if (state_q == SH_LOW && tick) rsh_q <= {rsh_q[DW-2:0], miso};
        end
    end

    always_comb begin
        run     = (state_q != SH_IDLE);
        sclk    = (state_q == SH_HIGH);
        cs_n    = (state_q == SH_IDLE);
        mosi    = tsh_q[DW-1];
        rx_byte = rsh_q;
    end

    // R6: a frame end with a byte waiting continues with select held and clock low
    p_chain_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && tx_full) |=> (!cs_n && !sclk && bit_q == '0));
    // R3: MOSI holds its value across the high phase of SCLK
    p_mosi_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));
endmodule

// File: rtl/spibm_txbuf.sv
module spibm_txbuf
    import spibm_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          data_wr,
    input  logic          stat_rd,
    input  logic          dma_en,
    input  logic          take,
    input  logic [DW-1:0] wdata,
    output logic          tx_full,
    output logic [DW-1:0] tx_data
);
    txb_state_t state_q, state_d;
    logic       accept;

    always_comb begin
        state_d = state_q;
        accept  = 1'b0;
        unique case (state_q)
            TXB_EMPTY: begin
                if (data_wr && dma_en) begin
                    accept  = 1'b1;
                    state_d = TXB_FULL;
                end else if (stat_rd) begin
                    state_d = TXB_ARMED;
                end
            end
            TXB_ARMED: begin
                if (data_wr) begin
                    accept  = 1'b1;
                    state_d = TXB_FULL;
                end
            end
            TXB_FULL: begin
                if (take) state_d = TXB_EMPTY;
            end
            default: state_d = TXB_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TXB_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      tx_data <= '0;
        else if (accept) tx_data <= wdata;
    end

    always_comb tx_full = (state_q == TXB_FULL);

    // R2: an unarmed write with DMA off leaves the buffer untouched
    p_unarmed_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TXB_EMPTY && data_wr && !dma_en) |=> (state_q != TXB_FULL && $stable(tx_data)));
    // R5: a write into a full buffer changes nothing
    p_full_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TXB_FULL && data_wr) |=> $stable(tx_data));
    // R12: the engine only takes a buffered byte, and the take empties the buffer
    p_take_full_r12: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (state_q == TXB_FULL));
    p_take_empties_r12: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (state_q == TXB_EMPTY));
endmodule

// File: rtl/spibm_rxbuf.sv
module spibm_rxbuf
    import spibm_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          done,
    input  logic [DW-1:0] rx_byte,
    input  logic          stat_rd,
    input  logic          data_rd,
    output logic          rx_full,
    output logic [DW-1:0] rx_data
);
    rxb_state_t state_q, state_d;
    logic       load;

    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        unique case (state_q)
            RXB_EMPTY: begin
                if (done) begin
                    load    = 1'b1;
                    state_d = RXB_FULL;
                end
            end
            RXB_FULL: begin
                if (stat_rd) state_d = RXB_ARMED;
            end
            RXB_ARMED: begin
                if (data_rd) begin
                    if (done) begin
                        load    = 1'b1;
                        state_d = RXB_FULL;
                    end else begin
                        state_d = RXB_EMPTY;
                    end
                end
            end
            default: state_d = RXB_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RXB_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    rx_data <= '0;
        else if (load) rx_data <= rx_byte;
    end

    always_comb rx_full = (state_q != RXB_EMPTY);

    // R9: a frame ending into an occupied buffer is dropped
    p_overrun_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != RXB_EMPTY && done && !(state_q == RXB_ARMED && data_rd))
        |=> ($stable(rx_data) && state_q != RXB_EMPTY));
    // R8: a data read without a prior status read keeps the flag
    p_unarmed_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RXB_FULL && data_rd) |=> (state_q != RXB_EMPTY));
    // R10: clearing read and frame end together leave the buffer full
    p_collide_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RXB_ARMED && data_rd && done) |=> (state_q == RXB_FULL));
endmodule

// File: rtl/spi_buffered_master.sv
module spi_buffered_master
    import spibm_pkg::*;
#(
    parameter int DW       = 8,
    parameter int HALF_DIV = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [1:0]    bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          dma_req,
    output logic          spi_sclk,
    output logic          spi_mosi,
    input  logic          spi_miso,
    output logic          spi_cs_n
);
    logic          stat_rd, data_rd, data_wr, ctrl_wr;
    logic          dma_en;
    logic          tx_full, rx_full;
    logic [DW-1:0] tx_data, rx_data, rx_byte;
    logic          run, tick, take, done;

    assign stat_rd = bus_sel && !bus_wr && (bus_addr == REG_STAT);
    assign data_rd = bus_sel && !bus_wr && (bus_addr == REG_DATA);
    assign data_wr = bus_sel &&  bus_wr && (bus_addr == REG_DATA);
    assign ctrl_wr = bus_sel &&  bus_wr && (bus_addr == REG_CTRL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       dma_en <= 1'b0;
        else if (ctrl_wr) dma_en <= bus_wdata[CTRL_DMA_BIT];
    end

    assign dma_req = dma_en && !tx_full;

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            REG_STAT: begin
                bus_rdata[STAT_TXE_BIT] = !tx_full;
                bus_rdata[STAT_RXF_BIT] = rx_full;
            end
            REG_CTRL: bus_rdata[CTRL_DMA_BIT] = dma_en;
            REG_DATA: bus_rdata = rx_data;
            default:  bus_rdata = '0;
        endcase
    end

    spibm_clkdiv #(.HALF_DIV(HALF_DIV)) u_div (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
    );

    spibm_txbuf #(.DW(DW)) u_tx (
        .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .stat_rd(stat_rd),
        .dma_en(dma_en), .take(take), .wdata(bus_wdata),
        .tx_full(tx_full), .tx_data(tx_data)
    );

    spibm_rxbuf #(.DW(DW)) u_rx (
        .clk(clk), .rst_n(rst_n), .done(done), .rx_byte(rx_byte),
        .stat_rd(stat_rd), .data_rd(data_rd),
        .rx_full(rx_full), .rx_data(rx_data)
    );

    spibm_shifter #(.DW(DW)) u_sh (
        .clk(clk), .rst_n(rst_n), .tick(tick), .tx_full(tx_full),
        .tx_data(tx_data), .miso(spi_miso), .run(run), .take(take),
        .done(done), .rx_byte(rx_byte), .sclk(spi_sclk),
        .mosi(spi_mosi), .cs_n(spi_cs_n)
    );

    // R4: a write while the request is raised is always accepted
    p_dma_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && data_wr) |=> tx_full);
    // R11: select is released whenever the serial clock is low and no frame runs
    p_idle_sel_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!run) |-> (spi_cs_n && !spi_sclk));
endmodule

// File: tb/spi_buffered_master_tb.sv
`timescale 1ns/1ps
module spi_buffered_master_tb;
    localparam int HALF = 2;
    localparam logic [1:0] A_STAT = 2'd0, A_CTRL = 2'd1, A_DATA = 2'd2;

    logic       clk = 1'b0, rst_n = 1'b0, sel = 1'b0, wr = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       dma_req, sclk, mosi, miso, cs_n;

    int checks = 0, fails = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    spi_buffered_master #(.DW(8), .HALF_DIV(HALF)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .dma_req(dma_req),
        .spi_sclk(sclk), .spi_mosi(mosi), .spi_miso(miso), .spi_cs_n(cs_n)
    );

    function automatic logic [7:0] slave_byte(int f);
        logic [7:0] x;
        x = 8'(f * 73 + 53);
        return x ^ 8'(f >> 3);
    endfunction

    // slave model and line monitor, all at the falling clock edge
    int cyc = 0, rise_cnt = 0, cs_rise = 0, cs_fall = 0, last_rise = 0, first_gap = 0, bad_gap = 0;
    logic [7:0] cap = '0, mosi_last = '0, cur_slave;
    logic sclk_p = 1'b0, cs_p = 1'b1;

    always_comb cur_slave = slave_byte(rise_cnt / 8);
    assign miso = cur_slave[3'(7 - (rise_cnt % 8))];

    always @(negedge clk) begin
        cyc++;
        if (sclk && !sclk_p) begin
            if (rise_cnt % 8 == 0) first_gap = cyc - last_rise;
            else if (cyc - last_rise != 2 * HALF) bad_gap++;
            last_rise = cyc;
            cap = {cap[6:0], mosi};
            if (rise_cnt % 8 == 7) mosi_last = cap;
            rise_cnt++;
        end
        if (!cs_n && cs_p) cs_fall++;
        if (cs_n && !cs_p) cs_rise++;
        sclk_p = sclk;
        cs_p   = cs_n;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b0; addr = a;
        #1 d = rdata;
        @(negedge clk);
        sel = 1'b0;
    endtask

    task automatic wait_rises(input int tgt);
        while (rise_cnt < tgt) begin
            @(negedge clk); #1;
        end
    endtask

    task automatic wait_idle();
        while (!cs_n) begin
            @(negedge clk); #1;
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] st, d;
        int base, f0, cr, fa;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;

        // R1 reset state
        check("R1 cs_n", int'(cs_n), 1);
        check("R1 sclk", int'(sclk), 0);
        check("R1 dma_req", int'(dma_req), 0);
        bus_read(A_DATA, d);  check("R1 data", d, 8'h00);
        bus_read(A_CTRL, d);  check("R1 ctrl", d, 8'h00);

        // R2 unarmed write ignored (no status read since reset)
        bus_write(A_DATA, 8'hA5);
        repeat (12) @(negedge clk);
        check("R2 no frame", cs_fall, 0);
        bus_read(A_STAT, st); check("R1 status", st, 8'h02);

        // R3 R7 R8 R12 sweep over every byte value
        for (int v = 0; v < 256; v++) begin
            bus_read(A_STAT, st);
            f0 = rise_cnt / 8;
            bus_write(A_DATA, 8'(v));
            if (v == 0) begin
                bus_read(A_STAT, st); check("R12 empty after take", st, 8'h02);
            end
            wait_rises((f0 + 1) * 8);
            wait_idle();
            check("R3 mosi byte", mosi_last, v);
            if (v % 32 == 5) begin
                bus_read(A_DATA, d);
                bus_read(A_STAT, st); check("R8 unarmed read keeps flag", st, 8'h03);
            end else begin
                bus_read(A_STAT, st);
                if (v % 32 == 0) check("R7 full flag", st, 8'h03);
            end
            bus_read(A_DATA, d);  check("R7 rx byte", d, slave_byte(f0));
            bus_read(A_STAT, st); check("R8 cleared", int'(st[0]), 0);
        end
        check("R11 half period", bad_gap, 0);

        // R3 arm consumed by the accepted write
        bus_read(A_STAT, st);
        base = rise_cnt;
        fa = base / 8;
        bus_write(A_DATA, 8'h3C);
        bus_write(A_DATA, 8'hC3);
        wait_rises(base + 8);
        wait_idle();
        repeat (20) @(negedge clk);
        check("R3 single frame", rise_cnt, base + 8);
        check("R3 first byte", mosi_last, 8'h3C);

        // R4 R5 R6 R9 DMA path, queued frames, overrun
        bus_write(A_CTRL, 8'h01);
        #1 check("R4 req raised", int'(dma_req), 1);
        base = rise_cnt;
        cr = cs_rise;
        bus_write(A_DATA, 8'h5A);
        bus_write(A_DATA, 8'h96);
        #1 check("R4 req dropped when full", int'(dma_req), 0);
        bus_write(A_DATA, 8'hFF);
        wait_rises(base + 16);
        wait_idle();
        repeat (20) @(negedge clk);
        check("R5 two frames only", rise_cnt, base + 16);
        check("R5 queued byte kept", mosi_last, 8'h96);
        check("R6 select held", cs_rise - cr, 1);
        check("R6 boundary gap", first_gap, 2 * HALF);
        check("R11 half period", bad_gap, 0);
        bus_read(A_STAT, st); check("R9 no overrun flag", st, 8'h03);
        bus_read(A_DATA, d);  check("R9 old byte kept", d, slave_byte(fa));
        bus_write(A_CTRL, 8'h00);
        #1 check("R4 req off", int'(dma_req), 0);

        // R10 clearing read in the frame-end cycle
        bus_read(A_STAT, st);
        base = rise_cnt;
        f0 = base / 8;
        bus_write(A_DATA, 8'h11);
        wait_rises(base + 8);
        wait_idle();
        bus_read(A_STAT, st);
        base = rise_cnt;
        bus_write(A_DATA, 8'hEE);
        wait_rises(base + 8);
        repeat (HALF - 1) @(posedge clk);
        bus_read(A_DATA, d);  check("R10 read returns old", d, slave_byte(f0));
        wait_idle();
        bus_read(A_STAT, st); check("R10 flag stays set", st, 8'h03);
        bus_read(A_DATA, d);  check("R10 new byte stored", d, slave_byte(f0 + 1));
        bus_read(A_STAT, st); check("R8 cleared after", st, 8'h02);
        check("R11 idle select", int'(cs_n), 1);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule